// File: doc/BRIEF.md
# Access Rights And Fault Checker

This block sits directly after a translation-buffer lookup. For each memory access it takes the rights fields of the entry that was hit, the privilege level and access kind of the requester, and the protection state of the processor. It returns the read, write and execute rights that may be cached for the page, plus a single fault code. The block is purely combinational. It does not look up translations and does not deliver exceptions.

Rights are decided in steps:
- A privilege window that depends on two level fields.
- A rights-type code that selects which of the window's rights apply.
- A protection-identifier match that takes away write.
- Three page attribute bits: dirty, break and reference.

The attribute bits are checked in a fixed order. Each one can also narrow the returned mask, so that a later access is checked again.

Privilege levels are 2-bit numbers, and a lower number means more privilege. The access kind is encoded as none = 0, read = 1, write = 2, execute = 3. The rights mask uses bit 0 for read, bit 1 for write and bit 2 for execute.

Top module: `arf_rights_checker`

## Requirements
- R1: When `phys_mode` is 1, `rights` is 3'b111 and `fault_code` is 0, whatever the other inputs are.
- R2: When `phys_mode` is 0 and the entry was not hit or is not valid, `rights` is 0. `fault_code` is 1 (instruction miss) for kind execute (3) and 2 (data miss) for every other kind, including none.
- R3: The privilege window is: read is allowed when priv <= level1, write when priv <= level2, and execute when level2 <= priv <= level1.
- R4: The type code picks the rights from the window: 0 gives read; 1 gives read and write; 2 gives read and execute; 3 gives read, write and execute; 4 to 7 give execute only.
- R5: When `prot_en` is 1 and the access id is not zero, the value id*2+1 is compared with each of the four identifier registers. If any register matches, write is removed from the mask. A write access then returns fault 3 (protection-id), and that fault takes precedence over every later check. A zero id, or `prot_en` at 0, has no effect.
- R6: Kind none (0) on a valid hit returns the mask left after R3 to R5, with fault 0. The attribute bits do not change that mask.
- R7: If the requested right is missing from the mask, the fault is 4 (instruction protection) for execute and 5 (data rights) for read or write. The mask is returned unchanged.
- R8: With the dirty bit clear, write is removed from the mask, and a write access gets fault 6.
- R9: With the break bit set, write is removed from the mask, and a write access gets fault 7. This overrides the fault from R8.
- R10: With the reference bit set, the mask is reduced to execute only, and a read or write access gets fault 8. This overrides the faults from R8 and R9. An execute access keeps whatever fault the earlier checks gave.
- R11: `fault_valid` is 1 exactly when `fault_code` is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phys_mode | input | 1 | Translation disabled; grant everything |
| ent_hit | input | 1 | Lookup found an entry covering the address |
| ent_valid | input | 1 | The found entry holds valid rights |
| ent_pl1 | input | 2 | Level bound for read and the upper bound for execute |
| ent_pl2 | input | 2 | Level bound for write and the lower bound for execute |
| ent_type | input | 3 | Rights-type code |
| ent_aid | input | 18 | Access identifier, 0 = public page |
| ent_break | input | 1 | Break bit |
| ent_dirty | input | 1 | Dirty bit |
| ent_ref | input | 1 | Reference-trap bit |
| req_priv | input | 2 | Privilege level of the requester |
| req_kind | input | 2 | Access kind: 0 none, 1 read, 2 write, 3 execute |
| prot_en | input | 1 | Protection-identifier checking enabled |
| pid_regs | input | 128 | Four 32-bit identifier registers, register i in bits [32i+31:32i] |
| rights | output | 3 | Granted mask: bit0 read, bit1 write, bit2 execute |
| fault_code | output | 4 | Fault code, 0 = no fault |
| fault_valid | output | 1 | A fault is reported |

## Verification
Several checks can apply in the same cycle, and the hard part is which one wins. The main conflicts are:
- An identifier match on a write, which must stop before the dirty and break faults.
- A clear dirty bit together with a set break bit on a write, where break must win.
- A set reference bit together with either of them.

The bench creates these overlaps with directed vectors and with random vectors, in which one identifier register is often loaded with the entry's matching value. A behavioural model applies the rules in order and picks the last fault that applies. Each cycle the mask and the code are compared with that model.

// File: rtl/arf_pkg.sv
package arf_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_EXEC  = 2'd3
   } acc_kind_e;

   typedef enum logic [3:0] {
      FLT_NONE    = 4'd0,
      FLT_IMISS   = 4'd1,
      FLT_DMISS   = 4'd2,
      FLT_PIDW    = 4'd3,
      FLT_IPROT   = 4'd4,
      FLT_DRIGHTS = 4'd5,
      FLT_DIRTY   = 4'd6,
      FLT_BREAK   = 4'd7,
      FLT_PREF    = 4'd8
   } fault_e;

   localparam int RGT_R = 0;
   localparam int RGT_W = 1;
   localparam int RGT_X = 2;
   localparam int RGT_N = 3;
endpackage

// File: rtl/arf_priv_window.sv
module arf_priv_window #(
   parameter int PL_W   = 2,
   parameter int TYPE_W = 3
) (
   input  logic [PL_W-1:0]   priv,
   input  logic [PL_W-1:0]   lvl1,
   input  logic [PL_W-1:0]   lvl2,
   input  logic [TYPE_W-1:0] rtype,
   output logic [2:0]        typed_mask
);
   import arf_pkg::*;

   localparam int EXEC_ONLY_BASE = 4;

   initial begin
      assert (TYPE_W >= 3) else $error("rights type code needs at least 3 bits");
      assert (PL_W >= 1) else $error("privilege width must be positive");
   end

   logic may_r, may_w, may_x;

   always_comb begin
      may_r = (priv <= lvl1);
      may_w = (priv <= lvl2);
      may_x = (lvl2 <= priv) && (priv <= lvl1);
      typed_mask = '0;
      if (rtype >= TYPE_W'(EXEC_ONLY_BASE)) begin
         typed_mask[RGT_X] = may_x;
      end else begin
         typed_mask[RGT_R] = may_r;
         typed_mask[RGT_W] = may_w && rtype[0];
         typed_mask[RGT_X] = may_x && rtype[1];
      end
   end

   // write is only ever offered by type codes 1 and 3
   always_comb begin
      if (!$isunknown({rtype, typed_mask}))
         assert_write_types_R4: assert (!typed_mask[RGT_W] || rtype == TYPE_W'(1) || rtype == TYPE_W'(3))
            else $error("write granted by a type without write");
   end

   // inside the window, execute implies read for the mixed types
   always_comb begin
      if (!$isunknown({rtype, typed_mask}))
         assert_exec_window_R3: assert (!(typed_mask[RGT_X] && rtype < TYPE_W'(EXEC_ONLY_BASE)) || typed_mask[RGT_R])
            else $error("execute granted outside privilege window");
   end
endmodule

// File: rtl/arf_pid_match.sv
module arf_pid_match #(
   parameter int  AID_W  = 18,
   parameter int  PID_W  = 32,
   parameter int  N_PID  = 4,
   parameter bit  PID_EN = 1'b1
) (
   input  logic [AID_W-1:0]       aid,
   input  logic                   prot_en,
   input  logic [N_PID*PID_W-1:0] pid_regs,
   output logic                   suppress
);
   localparam int KEY_W = AID_W + 1;

   initial begin
      assert (PID_W >= KEY_W) else $error("identifier register narrower than id*2+1");
      assert (N_PID >= 1) else $error("need at least one identifier register");
   end

   generate
      if (PID_EN) begin : g_cmp
         logic [PID_W-1:0] key;
         logic [N_PID-1:0] hit_vec;
         assign key = PID_W'({aid, 1'b1});
         for (genvar i = 0; i < N_PID; i++) begin : g_reg
            assign hit_vec[i] = (pid_regs[i*PID_W +: PID_W] == key);
         end
         assign suppress = prot_en && (aid != '0) && (|hit_vec);
      end else begin : g_off
         logic unused_in;
         assign unused_in = ^{aid, prot_en, pid_regs};
         assign suppress  = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!$isunknown({suppress, prot_en, aid}))
         assert_pid_gate_R5: assert (!suppress || (prot_en && aid != '0))
            else $error("write suppressed without protection enabled and a private id");
   end
endmodule

// File: rtl/arf_fault_order.sv
module arf_fault_order (
   input  logic [2:0] in_mask,
   input  logic [1:0] kind,
   input  logic       pid_hit,
   input  logic       dirty,
   input  logic       brk,
   input  logic       refb,
   output logic [2:0] out_mask,
   output logic [3:0] fault
);
   import arf_pkg::*;

   logic [2:0] req_bit;
   fault_e     f;

   always_comb begin
      req_bit = '0;
      unique case (acc_kind_e'(kind))
         ACC_READ:  req_bit[RGT_R] = 1'b1;
         ACC_WRITE: req_bit[RGT_W] = 1'b1;
         ACC_EXEC:  req_bit[RGT_X] = 1'b1;
         default:   req_bit = '0;
      endcase
   end

   always_comb begin
      out_mask = in_mask;
      f        = FLT_NONE;
      if (pid_hit) out_mask[RGT_W] = 1'b0;
      if (pid_hit && kind == ACC_WRITE) begin
         f = FLT_PIDW;
      end else if (kind == ACC_NONE) begin
         f = FLT_NONE;
      end else if ((out_mask & req_bit) == '0) begin
         f = (kind == ACC_EXEC) ? FLT_IPROT : FLT_DRIGHTS;
      end else begin
         if (!dirty) begin
            if (kind == ACC_WRITE) f = FLT_DIRTY;
            out_mask[RGT_W] = 1'b0;
         end
         if (brk) begin
            if (kind == ACC_WRITE) f = FLT_BREAK;
            out_mask[RGT_W] = 1'b0;
         end
         if (refb) begin
            if (kind != ACC_EXEC) f = FLT_PREF;
            out_mask = out_mask & (3'b1 << RGT_X);
         end
      end
      fault = f;
   end

   // no right may ever be added by the ordered checks
   always_comb begin
      if (!$isunknown({in_mask, out_mask}))
         assert_mask_shrinks_R8: assert ((out_mask & ~in_mask) == '0)
            else $error("ordered checks added a right");
   end

   // a reference fault leaves at most execute
   always_comb begin
      if (!$isunknown({fault, out_mask}))
         assert_ref_exec_only_R10: assert (fault != FLT_PREF || out_mask[RGT_R] == 1'b0 && out_mask[RGT_W] == 1'b0)
            else $error("reference fault with read or write still granted");
   end

   // break fault only for writes with the break bit set
   always_comb begin
      if (!$isunknown({fault, kind, brk, refb}))
         assert_break_write_R9: assert (fault != FLT_BREAK || (kind == ACC_WRITE && brk))
            else $error("break fault on wrong access");
   end
endmodule

// File: rtl/arf_rights_checker.sv
module arf_rights_checker #(
   parameter int PL_W   = 2,
   parameter int TYPE_W = 3,
   parameter int AID_W  = 18,
   parameter int PID_W  = 32,
   parameter int N_PID  = 4,
   parameter bit PID_EN = 1'b1
) (
   input  logic                   phys_mode,
   input  logic                   ent_hit,
   input  logic                   ent_valid,
   input  logic [PL_W-1:0]        ent_pl1,
   input  logic [PL_W-1:0]        ent_pl2,
   input  logic [TYPE_W-1:0]      ent_type,
   input  logic [AID_W-1:0]       ent_aid,
   input  logic                   ent_break,
   input  logic                   ent_dirty,
   input  logic                   ent_ref,
   input  logic [PL_W-1:0]        req_priv,
   input  logic [1:0]             req_kind,
   input  logic                   prot_en,
   input  logic [N_PID*PID_W-1:0] pid_regs,
   output logic [2:0]             rights,
   output logic [3:0]             fault_code,
   output logic                   fault_valid
);
   import arf_pkg::*;

   localparam logic [2:0] ALL_RIGHTS = {RGT_N{1'b1}};

   logic [2:0] typed_mask;
   logic       pid_sup;
   logic [2:0] ord_mask;
   logic [3:0] ord_fault;

   arf_priv_window #(.PL_W(PL_W), .TYPE_W(TYPE_W)) u_window (
      .priv       (req_priv),
      .lvl1       (ent_pl1),
      .lvl2       (ent_pl2),
      .rtype      (ent_type),
      .typed_mask (typed_mask)
   );

   arf_pid_match #(.AID_W(AID_W), .PID_W(PID_W), .N_PID(N_PID), .PID_EN(PID_EN)) u_pid (
      .aid      (ent_aid),
      .prot_en  (prot_en),
      .pid_regs (pid_regs),
      .suppress (pid_sup)
   );

   arf_fault_order u_order (
      .in_mask  (typed_mask),
      .kind     (req_kind),
      .pid_hit  (pid_sup),
      .dirty    (ent_dirty),
      .brk      (ent_break),
      .refb     (ent_ref),
      .out_mask (ord_mask),
      .fault    (ord_fault)
   );

   always_comb begin
      if (phys_mode) begin
         rights     = ALL_RIGHTS;
         fault_code = FLT_NONE;
      end else if (!ent_hit || !ent_valid) begin
         rights     = '0;
         fault_code = (req_kind == ACC_EXEC) ? FLT_IMISS : FLT_DMISS;
      end else begin
         rights     = ord_mask;
         fault_code = ord_fault;
      end
      fault_valid = (fault_code != FLT_NONE);
   end

   always_comb begin
      if (!$isunknown({phys_mode, rights, fault_code}))
         assert_phys_grant_R1: assert (!phys_mode || (rights == ALL_RIGHTS && fault_code == FLT_NONE))
            else $error("physical mode not fully granted");
   end

   always_comb begin
      if (!$isunknown({phys_mode, ent_hit, ent_valid, rights}))
         assert_miss_empty_R2: assert (phys_mode || (ent_hit && ent_valid) || rights == '0)
            else $error("rights granted on a miss");
   end

   always_comb begin
      if (!$isunknown({phys_mode, ent_hit, ent_valid, req_kind, fault_code}))
         assert_probe_quiet_R6: assert (phys_mode || !(ent_hit && ent_valid) || req_kind != ACC_NONE || fault_code == FLT_NONE)
            else $error("probe access raised a fault");
   end

   always_comb begin
      if (!$isunknown({pid_sup, rights, phys_mode}))
         assert_pid_nowrite_R5: assert (phys_mode || !pid_sup || !rights[RGT_W])
            else $error("write granted despite identifier match");
   end
endmodule

// File: tb/arf_rights_checker_bench.sv
module arf_rights_checker_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic         phys_mode, ent_hit, ent_valid;
   logic [1:0]   ent_pl1, ent_pl2, req_priv, req_kind;
   logic [2:0]   ent_type;
   logic [17:0]  ent_aid;
   logic         ent_break, ent_dirty, ent_ref, prot_en;
   logic [127:0] pid_regs;
   logic [2:0]   rights;
   logic [3:0]   fault_code;
   logic         fault_valid;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   arf_rights_checker u_arf_rights_checker (
      .phys_mode(phys_mode), .ent_hit(ent_hit), .ent_valid(ent_valid),
      .ent_pl1(ent_pl1), .ent_pl2(ent_pl2), .ent_type(ent_type), .ent_aid(ent_aid),
      .ent_break(ent_break), .ent_dirty(ent_dirty), .ent_ref(ent_ref),
      .req_priv(req_priv), .req_kind(req_kind), .prot_en(prot_en), .pid_regs(pid_regs),
      .rights(rights), .fault_code(fault_code), .fault_valid(fault_valid)
   );

   // behavioural model: rules applied in their stated order
   task automatic model(output logic [2:0] m, output logic [3:0] f, output string tag);
      bit r, w, x, idm;
      int p, a, b;
      p = req_priv; a = ent_pl1; b = ent_pl2;
      if (phys_mode) begin m = 3'b111; f = 0; tag = "R1"; return; end
      if (!ent_hit || !ent_valid) begin
         m = 0; f = (req_kind == 3) ? 4'd1 : 4'd2; tag = "R2"; return;
      end
      r = (p <= a); w = (p <= b); x = (b <= p) && (p <= a);
      case (ent_type)
         3'd0: m = {1'b0, 1'b0, r};
         3'd1: m = {1'b0, w, r};
         3'd2: m = {x, 1'b0, r};
         3'd3: m = {x, w, r};
         default: m = {x, 1'b0, 1'b0};
      endcase
      tag = "R3/R4";
      f = 0;
      idm = 0;
      if (prot_en && ent_aid != 0)
         for (int i = 0; i < 4; i++)
            if (pid_regs[i*32 +: 32] == {13'd0, ent_aid, 1'b1}) idm = 1;
      if (idm) begin
         m[1] = 0; tag = "R5";
         if (req_kind == 2) begin f = 3; return; end
      end
      if (req_kind == 0) begin tag = "R6"; return; end
      if (m[req_kind - 1] == 0) begin
         f = (req_kind == 3) ? 4'd4 : 4'd5; tag = "R7"; return;
      end
      if (!ent_dirty) begin
         if (req_kind == 2) f = 6;
         m[1] = 0; tag = "R8";
      end
      if (ent_break) begin
         if (req_kind == 2) f = 7;
         m[1] = 0; tag = "R9";
      end
      if (ent_ref) begin
         if (req_kind != 3) f = 8;
         m = m & 3'b100; tag = "R10";
      end
   endtask

   task automatic compare();
      logic [2:0] em;
      logic [3:0] ef;
      string tg;
      model(em, ef, tg);
      n_checks++;
      if (rights !== em || fault_code !== ef) begin
         n_fail++;
         $display("FAIL %s: rights=%b fault=%0d expected rights=%b fault=%0d", tg, rights, fault_code, em, ef);
      end
      n_checks++;
      if (fault_valid !== (ef != 0)) begin
         n_fail++;
         $display("FAIL R11: fault_valid=%b expected %b", fault_valid, (ef != 0));
      end
   endtask

   task automatic set_entry(bit ph, bit h, bit v, logic [1:0] l1, logic [1:0] l2, logic [2:0] ty,
                            logic [17:0] id, bit bk, bit dt, bit rf, logic [1:0] pv, logic [1:0] kd,
                            bit pe, logic [127:0] pr);
      @(posedge clk);
      #1;
      phys_mode = ph; ent_hit = h; ent_valid = v; ent_pl1 = l1; ent_pl2 = l2; ent_type = ty;
      ent_aid = id; ent_break = bk; ent_dirty = dt; ent_ref = rf; req_priv = pv; req_kind = kd;
      prot_en = pe; pid_regs = pr;
      @(negedge clk);
      compare();
   endtask

   initial begin
      phys_mode = 1; ent_hit = 0; ent_valid = 0; ent_pl1 = 0; ent_pl2 = 0; ent_type = 0;
      ent_aid = 0; ent_break = 0; ent_dirty = 0; ent_ref = 0; req_priv = 0; req_kind = 0;
      prot_en = 0; pid_regs = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare();                                                             // R1 idle state
      set_entry(1, 0, 0, 0, 0, 0, 0, 1, 0, 1, 3, 2, 1, '0);                  // R1 with faulting fields
      set_entry(0, 0, 1, 3, 3, 3, 0, 0, 1, 0, 0, 3, 0, '0);                  // R2 instruction miss
      set_entry(0, 1, 0, 3, 3, 3, 0, 0, 1, 0, 0, 0, 0, '0);                  // R2 probe on invalid -> data miss
      set_entry(0, 1, 1, 2, 1, 3, 0, 0, 1, 0, 1, 3, 0, '0);                  // R3 execute inside window
      set_entry(0, 1, 1, 2, 1, 3, 0, 0, 1, 0, 2, 2, 0, '0);                  // R3/R7 write above level2
      set_entry(0, 1, 1, 3, 3, 6, 0, 0, 1, 0, 0, 1, 0, '0);                  // R4/R7 exec-only type read
      set_entry(0, 1, 1, 3, 3, 1, 18'h5, 0, 1, 0, 0, 2, 1, {96'd0, 32'hB});  // R5 id match write
      set_entry(0, 1, 1, 3, 3, 1, 18'h5, 0, 1, 0, 0, 2, 0, {96'd0, 32'hB});  // R5 protection disabled
      set_entry(0, 1, 1, 3, 3, 1, 18'h0, 0, 1, 0, 0, 2, 1, {96'd0, 32'h1});  // R5 public id
      set_entry(0, 1, 1, 3, 3, 3, 0, 1, 0, 1, 0, 0, 0, '0);                  // R6 probe ignores bits
      set_entry(0, 1, 1, 3, 3, 1, 0, 0, 0, 0, 0, 2, 0, '0);                  // R8 dirty fault
      set_entry(0, 1, 1, 3, 3, 1, 0, 1, 0, 0, 0, 2, 0, '0);                  // R9 break over dirty
      set_entry(0, 1, 1, 3, 3, 1, 0, 1, 0, 1, 0, 2, 0, '0);                  // R10 reference over break
      set_entry(0, 1, 1, 3, 0, 3, 0, 0, 1, 1, 0, 3, 0, '0);                  // R10 execute untouched
      for (int k = 0; k < 4000; k++) begin
         logic [127:0] pr;
         logic [17:0]  id;
         id = ($urandom % 4 == 0) ? 18'd0 : 18'($urandom);
         pr = {$urandom, $urandom, $urandom, $urandom};
         if ($urandom % 2 == 0) pr[($urandom % 4)*32 +: 32] = {13'd0, id, 1'b1};
         set_entry(($urandom % 16) == 0, ($urandom % 8) != 0, ($urandom % 8) != 0,
                   2'($urandom), 2'($urandom), 3'($urandom), id,
                   1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                   1'($urandom), pr);
      end
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule